// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned operands and an incoming carry, producing a sum of the operand width and a carry-out. The operand is cut into equal groups of bits. The lowest group is one ripple adder fed by the real carry-in. Each higher group holds two copies of its adder. One copy assumes its incoming carry is 0 and the other assumes it is 1. Both copies settle at the same time as every other group.

The carry that actually leaves a group drives a 2:1 selector in the next group. That one select signal picks both the group's sum bits and its carry-out. The delay from the lowest group to the top is therefore one selector per group, not a ripple through every bit. Inside each adder copy the per-bit propagate and generate terms are formed first, then the carries ripple across the group, and then the sum bits are formed.

The adding network itself is combinational. The sum and carry-out are captured in output registers, so a result appears one clock after its operands. With the default parameters the adder is 16 bits wide, in four groups of 4 bits.

Top module: `carry_select_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` and `cout_q` become 0 after that edge, whatever the operands are.
- R2: With `rst` low, after each rising edge `{cout_q, sum_q}` equals `op_a + op_b + cin` as sampled at that edge, with `cout_q` as bit 16 of the 17-bit unsigned total.
- R3: `cin` enters at bit 0: the sum of 0x0000, 0x0000 and `cin`=1 is 0x0001 with carry-out 0.
- R4: A carry leaving the lowest group (bits 3..0) selects the carry-1 result of the group for bits 7..4: 0x000F + 0x0001 gives 0x0010.
- R5: A carry-in that propagates through every group reaches the carry-out: 0xFFFF + 0x0000 with `cin`=1 gives sum 0x0000 and carry-out 1.
- R6: A carry crossing three group boundaries selects correctly in each group: 0x0FFF + 0x0001 gives 0x1000 with carry-out 0.
- R7: The largest inputs, 0xFFFF + 0xFFFF with `cin`=1, give sum 0xFFFF and carry-out 1.
- R8: With no carry produced anywhere (0x0000 + 0x0000, `cin`=0) the sum and carry-out are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_q | output | 16 | Registered sum |
| cout_q | output | 1 | Registered carry-out of the top bit |

## Verification
If a group chooses the wrong one of its two precomputed results, the error shows as a whole nibble of `sum_q` that is off by one. If the wrong copy's carry is chosen, the error can spread upward into every later group and into `cout_q`. In both cases the fault appears one clock after the operands that expose it. Such operands are ones whose carry into that group differs from the other copy's assumption. The boundary operands are picked so that each group sees both incoming carry values, and random operands cover the mixed cases.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Default geometry of the adder
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_GROUP = 4;

  // Number of groups for a given width and group size
  function automatic int unsigned group_count(input int unsigned width,
                                              input int unsigned gsize);
    return (width + gsize - 1) / gsize;
  endfunction
endpackage

// File: rtl/csel_rca_group.sv
// One group-wide ripple adder: P/G first, then the carry chain, then the sums.
module csel_rca_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          ci,
  output logic [GW-1:0] s,
  output logic          co
);
  logic [GW-1:0] prop;
  logic [GW-1:0] gen;
  logic [GW:0]   chain;

  assign prop     = a ^ b;
  assign gen      = a & b;
  assign chain[0] = ci;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
  end

  assign s  = prop ^ chain[GW-1:0];
  assign co = chain[GW];
endmodule

// File: rtl/csel_spec_group.sv
// Speculative group: two adders for an assumed carry of 0 and of 1, then a
// selector driven by the real incoming carry. The same select picks the sum
// bits and the carry-out.
module csel_spec_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          sel,
  output logic [GW-1:0] s,
  output logic          co
);
  logic [GW-1:0] sum_if0, sum_if1;
  logic          co_if0, co_if1;

  csel_rca_group #(.GW(GW)) u_assume0 (
    .a(a), .b(b), .ci(1'b0), .s(sum_if0), .co(co_if0)
  );

  csel_rca_group #(.GW(GW)) u_assume1 (
    .a(a), .b(b), .ci(1'b1), .s(sum_if1), .co(co_if1)
  );

  always_comb begin
    if (sel) begin
      s  = sum_if1;
      co = co_if1;
    end else begin
      s  = sum_if0;
      co = co_if0;
    end
  end
endmodule

// File: rtl/carry_select_adder.sv
// Carry-select adder with registered outputs. WIDTH must be a multiple of GROUP.
module carry_select_adder
  import csel_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout_q
);
  localparam int unsigned NGRP = group_count(WIDTH, GROUP);

  logic [NGRP:0]    gcarry;
  logic [WIDTH-1:0] sum_d;

  assign gcarry[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == 0) begin : g_base
      csel_rca_group #(.GW(GROUP)) u_base (
        .a (op_a[GROUP-1:0]),
        .b (op_b[GROUP-1:0]),
        .ci(gcarry[0]),
        .s (sum_d[GROUP-1:0]),
        .co(gcarry[1])
      );
    end else begin : g_spec
      csel_spec_group #(.GW(GROUP)) u_spec (
        .a  (op_a[g*GROUP +: GROUP]),
        .b  (op_b[g*GROUP +: GROUP]),
        .sel(gcarry[g]),
        .s  (sum_d[g*GROUP +: GROUP]),
        .co (gcarry[g+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= gcarry[NGRP];
    end
  end
endmodule

// File: rtl/carry_select_adder_chk.sv
module carry_select_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             cin,
  input logic [WIDTH-1:0] sum_q,
  input logic             cout_q
);
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sum_q == ZERO && !cout_q)); // R1

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_q, sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}
                                  + {{WIDTH{1'b0}}, $past(cin)}))); // R2

  AST_CIN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (op_a == ZERO && op_b == ZERO && cin) |=> (sum_q == 1 && !cout_q)); // R3

  AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (op_a == ONES && op_b == ZERO && cin) |=> (sum_q == ZERO && cout_q)); // R5

  AST_MAX_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (op_a == ONES && op_b == ONES && cin) |=> (sum_q == ONES && cout_q)); // R7

  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
    (op_a == ZERO && op_b == ZERO && !cin) |=> (sum_q == ZERO && !cout_q)); // R8
endmodule

bind carry_select_adder carry_select_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .cin(cin),
  .sum_q(sum_q), .cout_q(cout_q)
);

// File: tb/carry_select_adder_test.sv
`timescale 1ns/1ps
module carry_select_adder_test;
  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_q;
  logic         cout_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference results, one per clock edge, in order of application
  logic [W:0] exp_q[$];

  always #5 clk = ~clk;

  carry_select_adder uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .cin(cin),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  task automatic check(input string tag);
    logic [W:0] exp = exp_q.pop_front();
    checks++;
    if ({cout_q, sum_q} !== exp) begin
      fails++;
      $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
               tag, cout_q, sum_q, exp[W], exp[W-1:0]);
    end
  endtask

  // Inputs change on the falling edge; the result is checked one falling edge later
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string tag);
    int total;
    op_a = a; op_b = b; cin = c;
    total = int'(a) + int'(b) + int'(c);
    exp_q.push_back(rst ? '0 : (W+1)'(total));
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R1 reset clear");
    apply(16'h1234, 16'h4321, 1'b1, "R1 reset clear");
    rst = 1'b0;
    apply(16'h0000, 16'h0000, 1'b0, "R8 zero");
    apply(16'h0000, 16'h0000, 1'b1, "R3 cin only");
    apply(16'h000F, 16'h0001, 1'b0, "R4 first boundary");
    apply(16'h000E, 16'h0000, 1'b1, "R3 cin into group");
    apply(16'hFFFF, 16'h0000, 1'b1, "R5 full propagate");
    apply(16'h0FFF, 16'h0001, 1'b0, "R6 three boundaries");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R7 max inputs");
    apply(16'hFFFF, 16'h0001, 1'b0, "R5 wrap");
    apply(16'h00FF, 16'h0000, 1'b1, "R6 two boundaries");
    apply(16'h7FFF, 16'h0001, 1'b0, "R2 top group");
    apply(16'h8000, 16'h8000, 1'b0, "R2 top carry");
    apply(16'hF0F0, 16'h0F0F, 1'b1, "R5 alternating");
    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "R2 random");
    end
    // Reset again in the middle of traffic
    rst = 1'b1;
    apply(16'hABCD, 16'h1111, 1'b1, "R1 reset mid-run");
    rst = 1'b0;
    apply(16'hABCD, 16'h1111, 1'b1, "R2 after reset");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no finish, expected finish within %0d cycles",
               WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule